// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Banked Masking

This block gathers a wide set of level-sensitive interrupt request lines into 32-bit banks and drives a single interrupt line to the processor. Every line has its own mask bit. Software never writes the mask directly. For each bank it has two words: one sets mask bits and the other clears them. A 1 in the written word selects a line, and a 0 leaves that line alone. A cleared mask bit enables its line.

When an enabled line is active, the controller raises its interrupt output. At the same moment it latches the lowest-numbered enabled active line into a read-only register, so software can find the source. Software handles a source in this order:

1. Mask the source.
2. Write the acknowledge bit in the control word.
3. Service the source.
4. Unmask the source.

After the acknowledge, the controller picks the next source.

A configuration bit starts a soft reset. The soft reset returns the masks and the latched source to their reset state. It lasts a fixed number of cycles, and a status bit reports when it has finished. A revision word identifies the block. Software reaches all registers over a plain synchronous bus with address, write enable, write data and registered read data. The value of `bus_rdata_o` is the register addressed at the previous clock edge.

Top module: `lvl_intc`

## Requirements
- R1: After `rst`, every mask bit is 1 and `irq_o` is 0. The status word at 0x014 reads bit 0 = 1. The active-source word at 0x040 reads 0.
- R2: The word at 0x000 returns the revision parameter (default 0x21) in bits 7:0: major version in bits 7:4, minor version in bits 3:0. All other bits are 0. `bus_rdata_o` shows the word addressed at the previous clock edge.
- R3: Source n belongs to bank n/32, at bit n%32. Writing a word to 0x088 + 0x20·bank clears the mask bit of every source whose bit is 1 in the word. Bits that are 0 leave their mask bit unchanged.
- R4: Writing a word to 0x08C + 0x20·bank sets the mask bit of every source whose bit is 1 in the word. Bits that are 0 leave their mask bit unchanged.
- R5: `irq_o` is registered. It is 1 in the cycle after one in which some source is active with its mask bit 0, no acknowledge is written and no soft reset is running. Otherwise it is 0 in the following cycle.
- R6: The word at 0x040 returns, in bits 6:0, the lowest-numbered active unmasked source. That number is latched in the cycle `irq_o` rises. It is held while `irq_o` stays 1, even if a lower-numbered source becomes active.
- R7: Writing 0x048 with bit 0 = 1 forces `irq_o` to 0 in the next cycle. The controller then selects and latches the next source. Writing 0x048 with bit 0 = 0 has no effect.
- R8: Writing 0x010 with bit 1 = 1 starts a soft reset, which sets every mask bit to 1 and clears the latched source. For the next SRST_CYCLES reads (default 4), bit 0 of 0x014 reads 0, and then it reads 1. `irq_o` stays 0 while the soft reset runs. Mask writes during the soft reset are ignored.
- R9: Reads of offsets that hold no register return 0. Writes to them change nothing. Mask addresses for banks beyond the last bank also count as unimplemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt request lines |
| bus_addr_i | input | 12 | Register byte offset |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The selection logic is tried with two pending sources in different banks. In one pattern the higher-numbered source is enabled first. Then the lower one is enabled while the first is still latched. This shows that the latched source is held rather than re-sorted, and that the next source appears only after the acknowledge.

Other patterns separate the effect of each mask operation:
- writes with all-zero words
- writes to a bank address that does not exist
- a source whose line drops before it is acknowledged

A final pattern gives mask writes landing inside a soft reset window. It shows that the soft reset state overrides software, and it measures the exact length of the not-done window through status polling.

// File: rtl/lvl_intc_pkg.sv
`timescale 1ns/1ps
package lvl_intc_pkg;

    localparam int BANK_W     = 32;
    localparam int BUS_AW     = 12;
    localparam int BUS_DW     = 32;
    localparam int BANK_IDX_W = 4;
    localparam int MAX_BANKS  = 1 << BANK_IDX_W;

    localparam logic [BUS_AW-1:0] OFS_REV     = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_SYSCFG  = 12'h010;
    localparam logic [BUS_AW-1:0] OFS_SYSSTAT = 12'h014;
    localparam logic [BUS_AW-1:0] OFS_ACTIVE  = 12'h040;
    localparam logic [BUS_AW-1:0] OFS_CTRL    = 12'h048;
    localparam logic [BUS_AW-1:0] OFS_MCLR0   = 12'h088;
    localparam logic [BUS_AW-1:0] OFS_MSET0   = 12'h08C;
    localparam logic [BUS_AW-1:0] BANK_STRIDE = 12'h020;

    localparam int CFG_SRST_BIT  = 1;
    localparam int STAT_DONE_BIT = 0;
    localparam int CTRL_ACK_BIT  = 0;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_REV,
        ACC_CFG,
        ACC_STAT,
        ACC_ACTIVE,
        ACC_CTRL,
        ACC_MCLR,
        ACC_MSET
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e               kind;
        logic [BANK_IDX_W-1:0]   bank;
    } acc_dec_t;

    // Maps a byte offset to a register kind and, for mask words, a bank.
    function automatic acc_dec_t decode_addr(input logic [BUS_AW-1:0] a,
                                             input int nbank);
        acc_dec_t d;
        d.kind = ACC_NONE;
        d.bank = '0;
        case (a)
            OFS_REV:     d.kind = ACC_REV;
            OFS_SYSCFG:  d.kind = ACC_CFG;
            OFS_SYSSTAT: d.kind = ACC_STAT;
            OFS_ACTIVE:  d.kind = ACC_ACTIVE;
            OFS_CTRL:    d.kind = ACC_CTRL;
            default:     d.kind = ACC_NONE;
        endcase
        for (int b = 0; b < MAX_BANKS; b++) begin
            if (b < nbank) begin
                if (a == OFS_MCLR0 + BUS_AW'(b) * BANK_STRIDE) begin
                    d.kind = ACC_MCLR;
                    d.bank = BANK_IDX_W'(b);
                end
                if (a == OFS_MSET0 + BUS_AW'(b) * BANK_STRIDE) begin
                    d.kind = ACC_MSET;
                    d.bank = BANK_IDX_W'(b);
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/lvl_intc_mask_bank.sv
`timescale 1ns/1ps
module lvl_intc_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         force_all,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst || force_all) begin
            mask <= '1;
        end else if (set_we) begin
            mask <= mask | bits;
        end else if (clr_we) begin
            mask <= mask & ~bits;
        end
    end

endmodule

// File: rtl/lvl_intc_prio.sv
`timescale 1ns/1ps
module lvl_intc_prio #(
    parameter int N   = 96,
    parameter int IDW = 7
) (
    input  logic [N-1:0]   req,
    output logic           any,
    output logic [IDW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/lvl_intc_srst.sv
`timescale 1ns/1ps
module lvl_intc_srst #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/lvl_intc.sv
`timescale 1ns/1ps
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int         NUM_SRC     = 96,
    parameter int         SRST_CYCLES = 4,
    parameter logic [7:0] REV         = 8'h21
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [BUS_AW-1:0]  bus_addr_i,
    input  logic               bus_we_i,
    input  logic [BUS_DW-1:0]  bus_wdata_i,
    output logic [BUS_DW-1:0]  bus_rdata_o,
    output logic               irq_o
);

    localparam int NUM_BANK = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int MASK_W   = NUM_BANK * BANK_W;
    localparam int ID_W     = $clog2(NUM_SRC);

    acc_dec_t          dec;
    logic [MASK_W-1:0] mask_all;
    logic [NUM_SRC-1:0] pend;
    logic              any_pend;
    logic [ID_W-1:0]   low_id;
    logic              srst_start;
    logic              srst_busy;
    logic              ack_wr;
    logic              busy_q;
    logic [ID_W-1:0]   act_id_q;
    logic [BUS_DW-1:0] rd_n;

    assign dec        = decode_addr(bus_addr_i, NUM_BANK);
    assign srst_start = bus_we_i && (dec.kind == ACC_CFG) && bus_wdata_i[CFG_SRST_BIT];
    assign ack_wr     = bus_we_i && (dec.kind == ACC_CTRL) && bus_wdata_i[CTRL_ACK_BIT];

    lvl_intc_srst #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk   (clk),
        .rst   (rst),
        .start (srst_start),
        .busy  (srst_busy)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic sel;
        assign sel = bus_we_i && (dec.bank == BANK_IDX_W'(b));
        lvl_intc_mask_bank #(.W(BANK_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .force_all (srst_start || srst_busy),
            .set_we    (sel && (dec.kind == ACC_MSET)),
            .clr_we    (sel && (dec.kind == ACC_MCLR)),
            .bits      (bus_wdata_i[BANK_W-1:0]),
            .mask      (mask_all[b*BANK_W +: BANK_W])
        );
    end

    assign pend = src_i & ~mask_all[NUM_SRC-1:0];

    lvl_intc_prio #(.N(NUM_SRC), .IDW(ID_W)) u_prio (
        .req (pend),
        .any (any_pend),
        .idx (low_id)
    );

    // Presentation state: raised on a pending source, dropped on ack or idle.
    always_ff @(posedge clk) begin
        if (rst || srst_start) begin
            busy_q   <= 1'b0;
            act_id_q <= '0;
        end else begin
            busy_q <= any_pend && !ack_wr && !srst_busy;
            if (!busy_q && any_pend && !ack_wr && !srst_busy) begin
                act_id_q <= low_id;
            end
        end
    end

    assign irq_o = busy_q;

    always_comb begin
        rd_n = '0;
        case (dec.kind)
            ACC_REV:    rd_n[7:0]            = REV;
            ACC_CFG:    rd_n[CFG_SRST_BIT]   = srst_busy;
            ACC_STAT:   rd_n[STAT_DONE_BIT]  = !srst_busy;
            ACC_ACTIVE: rd_n[ID_W-1:0]       = act_id_q;
            default:    rd_n                 = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata_o <= '0;
        end else begin
            bus_rdata_o <= rd_n;
        end
    end

endmodule

// File: rtl/lvl_intc_chk.sv
`timescale 1ns/1ps
module lvl_intc_chk
    import lvl_intc_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int MASK_W  = 96,
    parameter int ID_W    = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [BUS_DW-1:0] bus_wdata_i,
    input logic              irq_o,
    input logic [MASK_W-1:0] mask_all,
    input logic              any_pend,
    input logic              srst_busy,
    input logic [ID_W-1:0]   act_id_q
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o);

    a_r5_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(any_pend));

    a_r6_id_held: assert property (@(posedge clk) disable iff (rst)
        (irq_o && $past(irq_o)) |-> $stable(act_id_q));

    a_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && bus_addr_i == OFS_CTRL && bus_wdata_i[CTRL_ACK_BIT]) |=> !irq_o);

    a_r8_quiet_in_srst: assert property (@(posedge clk) disable iff (rst)
        srst_busy |-> !irq_o);

    a_r4_set_bank0: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && bus_addr_i == OFS_MSET0 && !srst_busy) |=>
        (mask_all[BANK_W-1:0] == ($past(mask_all[BANK_W-1:0]) | $past(bus_wdata_i))));

    a_r3_clr_bank0: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && bus_addr_i == OFS_MCLR0 && !srst_busy) |=>
        (mask_all[BANK_W-1:0] == ($past(mask_all[BANK_W-1:0]) & ~$past(bus_wdata_i))));

endmodule

bind lvl_intc lvl_intc_chk #(
    .NUM_SRC (NUM_SRC),
    .MASK_W  (MASK_W),
    .ID_W    (ID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .mask_all    (mask_all),
    .any_pend    (any_pend),
    .srst_busy   (srst_busy),
    .act_id_q    (act_id_q)
);

// File: tb/lvl_intc_tb.sv
`timescale 1ns/1ps
module lvl_intc_tb;

    localparam int NSRC = 96;
    localparam int SRST = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic [11:0]     addr = '0;
    logic            we = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq;
    logic            rd_vld = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    lvl_intc u_dut (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Monitor: compares registered read data with the scoreboard head.
    always @(posedge clk) begin
        #2;
        if (rd_vld) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard: read with no expected item, actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        addr = a; we = 1'b0; rd_vld = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_vld = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq_o actual %b expected %b", t, irq, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(12'h014, 32'h1, "R1 status done after reset");
        rd(12'h040, 32'h0, "R1 active source after reset");
        // R2 revision
        rd(12'h000, 32'h21, "R2 revision word");
        // R9 unimplemented read
        rd(12'h004, 32'h0, "R9 unimplemented read");

        // R1 all masked: pending lines do not raise irq
        src[5] = 1'b1;
        src[40] = 1'b1;
        cyc(2);
        chk_irq(1'b0, "R1 masked sources stay quiet");

        // R3 unmask source 40 (bank 1 bit 8), R5 irq timing
        wr(12'h0A8, 32'h1 << 8);
        chk_irq(1'b0, "R5 irq not yet high");
        cyc(1);
        chk_irq(1'b1, "R5 irq raised");
        rd(12'h040, 32'd40, "R6 active source 40");

        // R6 lower source appears while 40 latched
        wr(12'h088, 32'h1 << 5);
        cyc(1);
        rd(12'h040, 32'd40, "R6 latched number held");
        chk_irq(1'b1, "R6 irq stays high");

        // R7 ack with bit0 = 0 has no effect
        wr(12'h048, 32'h0);
        chk_irq(1'b1, "R7 ack bit clear ignored");
        rd(12'h040, 32'd40, "R7 ack bit clear keeps number");

        // R4 mask 40, then R7 acknowledge
        wr(12'h0AC, 32'h1 << 8);
        wr(12'h048, 32'h1);
        chk_irq(1'b0, "R7 irq dropped by ack");
        cyc(1);
        chk_irq(1'b1, "R7 next source presented");
        rd(12'h040, 32'd5, "R7 next source is 5");

        // R4 zero-bit set word leaves source 5 enabled
        wr(12'h08C, 32'h0);
        cyc(1);
        chk_irq(1'b1, "R4 zero bits leave mask");
        // R3 zero-bit clear word leaves source 40 masked
        wr(12'h0A8, 32'h0);
        wr(12'h08C, 32'h1 << 5);
        wr(12'h048, 32'h1);
        cyc(2);
        chk_irq(1'b0, "R3 zero bits leave mask set");

        // R5 source removal drops irq
        wr(12'h0A8, 32'h1 << 8);
        cyc(1);
        chk_irq(1'b1, "R5 irq for 40 again");
        rd(12'h040, 32'd40, "R6 active 40 again");
        src[40] = 1'b0;
        cyc(1);
        chk_irq(1'b0, "R5 irq falls when line drops");

        // R9 writes to unimplemented offsets, incl. nonexistent bank 3
        src[70] = 1'b1;
        wr(12'h0E8, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        cyc(2);
        chk_irq(1'b0, "R9 unimplemented writes ignored");
        // R3 bank 2 mapping: source 70 = bank 2 bit 6
        wr(12'h0C8, 32'h1 << 6);
        cyc(1);
        chk_irq(1'b1, "R3 bank 2 source enabled");
        rd(12'h040, 32'd70, "R3 active source 70");

        // R8 soft reset and status window
        wr(12'h010, 32'h2);
        chk_irq(1'b0, "R8 irq low in soft reset");
        for (int i = 0; i < SRST; i++) begin
            rd(12'h014, 32'h0, "R8 status not done");
        end
        rd(12'h014, 32'h1, "R8 status done");
        cyc(2);
        chk_irq(1'b0, "R8 masks restored to set");
        rd(12'h040, 32'h0, "R8 active source cleared");

        // R8 mask write inside soft reset window is ignored
        wr(12'h010, 32'h2);
        wr(12'h0C8, 32'h1 << 6);
        cyc(SRST + 2);
        chk_irq(1'b0, "R8 mask write during reset ignored");
        wr(12'h0C8, 32'h1 << 6);
        cyc(1);
        chk_irq(1'b1, "R8 operation resumes after reset");

        cyc(3);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: %0d reads unchecked, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule